// File: doc/BRIEF.md
# Doze CPU Clock Divider

This block lets the CPU run at a lower rate while everything else keeps running from the same system clock at full speed. It does not gate or derive a new clock. It produces a clock-enable strobe that is aligned to the system clock, and the CPU advances only on cycles where that strobe is high. Because the strobe is a qualifier on the shared clock and not a separate clock, the CPU and the peripherals stay in one synchronous domain. Peripherals can therefore keep exchanging register accesses with the CPU while it runs slowly.

Software sets a doze enable and a 3-bit divide code. An optional wake-on-interrupt mode returns the CPU to full speed when an interrupt request arrives. The block reports the resulting enable value on `dozeEnNext`, so the control register can take that value back. A down-counter spaces the strobes. A new setting is loaded only when the counter reaches terminal count, so the CPU cycle already in progress is never cut short.

Top module: `doze_clk_div`

## Requirements
- R1: After reset, `cpuClkEn` is high in the first cycle and every following cycle (ratio 1:1), as long as `dozeEn` stays low.
- R2: While the effective enable `dozeEnNext` is low, `cpuClkEn` is high every cycle, whatever the value of `dozeRatio`.
- R3: While `dozeEnNext` is high, `cpuClkEn` pulses once every N system cycles. N depends on `dozeRatio`: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 32, 6 gives 64.
- R4: When N is greater than 1, each `cpuClkEn` pulse lasts exactly one system cycle.
- R5: A change to `dozeEn` or `dozeRatio` between two pulses does not change the length of the interval in progress. The new N applies from the pulse that ends that interval.
- R6: When `returnOnIrq` and `dozeEn` are high and `irqPulse` is sampled high, `dozeEnNext` goes low from the next cycle. It stays low until `dozeEn` is driven low. The interval in progress finishes at its old length, and full speed follows.
- R7: When `returnOnIrq` is low, `irqPulse` has no effect on `dozeEnNext` or on the spacing of the strobes.
- R8: Code 7 selects 1:256, not 1:128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared by the CPU and the peripherals |
| rstN | input | 1 | Asynchronous active-low reset |
| dozeEn | input | 1 | Doze enable from the control register |
| dozeRatio | input | 3 | Divide code (encoding in R3, R8) |
| returnOnIrq | input | 1 | Enables leaving doze when an interrupt arrives |
| irqPulse | input | 1 | Interrupt request, sampled every cycle |
| cpuClkEn | output | 1 | CPU clock-enable strobe |
| dozeEnNext | output | 1 | Effective doze enable, for write-back to the control register |

## Verification
A table drives all eight divide codes with doze on, and high codes with doze off. This separates the power-of-two codes from the special top code and shows that the enable, not the code, selects full speed. Each setting is measured over two consecutive intervals. The first shows that the setting is loaded at the boundary. The second shows that the spacing holds steady. Directed tests then change the divide code mid-interval and raise interrupts with wake-on-interrupt on and off. These tests separate an immediate reload from a reload at the boundary, and a honoured interrupt from an ignored one.

// File: rtl/doze_pkg.sv
package doze_pkg;

  // Strobes from the control side to the counter datapath.
  typedef struct packed {
    logic load;  // reload the counter with the new interval length
    logic step;  // count down by one
  } dozeStrb_t;

  // Interval length (in system cycles) for one divide code.
  function automatic int unsigned divOf(int unsigned code, int unsigned codes,
                                        int unsigned topLog2);
    if (code == codes - 1) return (32'd1 << topLog2);
    return (32'd1 << code);
  endfunction

endpackage

// File: rtl/doze_ratio_dec.sv
module doze_ratio_dec #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned TOP_LOG2 = 8,
  parameter int unsigned CNT_W    = TOP_LOG2
) (
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic [CNT_W-1:0]  loadVal
);
  import doze_pkg::*;

  localparam int unsigned CODES = 1 << CODE_W;

  logic [CNT_W-1:0] reloadTbl [CODES];

  // One reload constant per code (interval length minus one).
  for (genvar g = 0; g < CODES; g++) begin : g_tbl
    localparam int unsigned DIVG = divOf(g, CODES, TOP_LOG2);
    assign reloadTbl[g] = (CNT_W)'(DIVG - 1);
  end

  assign loadVal = enable ? reloadTbl[code] : '0;

endmodule

// File: rtl/doze_ctrl.sv
module doze_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dozeEn,
  input  logic               returnOnIrq,
  input  logic               irqPulse,
  input  logic               atTerm,
  output logic               dozeEnNext,
  output doze_pkg::dozeStrb_t strb
);
  logic wakeHold;

  // Set by an interrupt while wake-on-interrupt is on.
  // Released once software drops the enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          wakeHold <= 1'b0;
    else if (!dozeEn)                   wakeHold <= 1'b0;
    else if (returnOnIrq && irqPulse)   wakeHold <= 1'b1;
  end

  assign dozeEnNext = dozeEn & ~wakeHold;

  always_comb begin
    strb.load = atTerm;
    strb.step = ~atTerm;
  end

endmodule

// File: rtl/doze_cnt.sv
module doze_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  doze_pkg::dozeStrb_t strb,
  input  logic [CNT_W-1:0]    loadVal,
  output logic                atTerm
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (strb.load) cnt <= loadVal;
    else if (strb.step) cnt <= cnt - 1'b1;
  end

  assign atTerm = (cnt == '0);

endmodule

// File: rtl/doze_clk_div.sv
module doze_clk_div #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned TOP_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dozeEn,
  input  logic [CODE_W-1:0] dozeRatio,
  input  logic              returnOnIrq,
  input  logic              irqPulse,
  output logic              cpuClkEn,
  output logic              dozeEnNext
);
  localparam int unsigned CNT_W = TOP_LOG2;

  doze_pkg::dozeStrb_t strb;
  logic [CNT_W-1:0]    loadVal;
  logic                atTerm;

  doze_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .dozeEn(dozeEn), .returnOnIrq(returnOnIrq),
    .irqPulse(irqPulse), .atTerm(atTerm), .dozeEnNext(dozeEnNext), .strb(strb)
  );

  doze_ratio_dec #(.CODE_W(CODE_W), .TOP_LOG2(TOP_LOG2), .CNT_W(CNT_W)) i_dec (
    .code(dozeRatio), .enable(dozeEnNext), .loadVal(loadVal)
  );

  doze_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .atTerm(atTerm)
  );

  assign cpuClkEn = atTerm;

endmodule

// File: rtl/doze_clk_div_chk.sv
module doze_clk_div_chk #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned TOP_LOG2 = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dozeEn,
  input logic [CODE_W-1:0] dozeRatio,
  input logic              returnOnIrq,
  input logic              irqPulse,
  input logic              cpuClkEn,
  input logic              dozeEnNext
);
  localparam int unsigned MAXDIV = 1 << TOP_LOG2;

  logic [TOP_LOG2:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         gapCnt <= '0;
    else if (cpuClkEn) gapCnt <= '0;
    else               gapCnt <= gapCnt + 1'b1;
  end

  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt < (TOP_LOG2+1)'(MAXDIV));

  // R2
  full_speed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && !dozeEnNext) |=> cpuClkEn);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && dozeEnNext && dozeRatio != '0) |=> !cpuClkEn);

  // R6
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dozeEn && returnOnIrq && irqPulse) |=> !dozeEnNext);

  // R7
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dozeEnNext) && dozeEn && $past(dozeEn)) |-> $past(returnOnIrq && irqPulse));

endmodule

bind doze_clk_div doze_clk_div_chk #(.CODE_W(CODE_W), .TOP_LOG2(TOP_LOG2)) i_chk (
  .clk(clk), .rstN(rstN), .dozeEn(dozeEn), .dozeRatio(dozeRatio),
  .returnOnIrq(returnOnIrq), .irqPulse(irqPulse), .cpuClkEn(cpuClkEn),
  .dozeEnNext(dozeEnNext)
);

// File: tb/test_doze_clk_div.sv
`timescale 1ns/1ps
module test_doze_clk_div;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dozeEn = 1'b0;
  logic [2:0] dozeRatio = 3'd0;
  logic returnOnIrq = 1'b0;
  logic irqPulse = 1'b0;
  logic cpuClkEn, dozeEnNext;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  doze_clk_div i_doze_clk_div (
    .clk(clk), .rstN(rstN), .dozeEn(dozeEn), .dozeRatio(dozeRatio),
    .returnOnIrq(returnOnIrq), .irqPulse(irqPulse),
    .cpuClkEn(cpuClkEn), .dozeEnNext(dozeEnNext)
  );

  localparam int NVEC = 11;
  localparam logic [3:0] VEC_CFG [NVEC] = '{4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC,
                                             4'hD, 4'hE, 4'hF, 4'h3, 4'hB};
  localparam int VEC_GAP [NVEC] = '{1, 1, 2, 4, 8, 16, 32, 64, 256, 1, 8};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!cpuClkEn);
  endtask

  task automatic measureGap(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cpuClkEn && gap < 1000);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: first cycle after reset strobes, then full speed
    check(cpuClkEn === 1'b1, "R1", cpuClkEn, 1);
    check(dozeEnNext === 1'b0, "R1", dozeEnNext, 0);
    measureGap(g);
    check(g == 1, "R1", g, 1);

    for (int i = 0; i < NVEC; i++) begin
      dozeEn = VEC_CFG[i][3];
      dozeRatio = VEC_CFG[i][2:0];
      waitStrobe();
      measureGap(g);  // R2 / R3 / R8 first interval after boundary
      check(g == VEC_GAP[i], VEC_CFG[i][3] ? (VEC_CFG[i][2:0] == 3'd7 ? "R8" : "R3") : "R2",
            g, VEC_GAP[i]);
      measureGap(g);  // R4: steady spacing, single-cycle pulses
      check(g == VEC_GAP[i], "R4", g, VEC_GAP[i]);
    end

    // R5: mid-interval change from 1:256 to 1:2
    dozeEn = 1'b1; dozeRatio = 3'd7;
    waitStrobe(); waitStrobe();
    g = 0;
    repeat (3) begin @(negedge clk); g++; end
    dozeRatio = 3'd1;
    while (!cpuClkEn && g < 1000) begin @(negedge clk); g++; end
    check(g == 256, "R5", g, 256);
    measureGap(g);
    check(g == 2, "R5", g, 2);

    // R7: interrupt ignored without wake-on-interrupt
    dozeRatio = 3'd2; returnOnIrq = 1'b0;
    waitStrobe(); waitStrobe();
    @(negedge clk); irqPulse = 1'b1;
    @(negedge clk); irqPulse = 1'b0;
    check(dozeEnNext === 1'b1, "R7", dozeEnNext, 1);
    waitStrobe();
    measureGap(g);
    check(g == 4, "R7", g, 4);

    // R6: interrupt with wake-on-interrupt
    returnOnIrq = 1'b1;
    waitStrobe();
    @(negedge clk); irqPulse = 1'b1;      // one cycle into a 4-cycle interval
    @(negedge clk); irqPulse = 1'b0;
    check(dozeEnNext === 1'b0, "R6", dozeEnNext, 0);
    check(cpuClkEn === 1'b0, "R6", cpuClkEn, 0);
    g = 2;
    while (!cpuClkEn && g < 1000) begin @(negedge clk); g++; end
    check(g == 4, "R6", g, 4);
    measureGap(g);
    check(g == 1, "R6", g, 1);
    repeat (3) @(negedge clk);
    check(dozeEnNext === 1'b0, "R6", dozeEnNext, 0);
    dozeEn = 1'b0;
    @(negedge clk);
    dozeEn = 1'b1;
    @(negedge clk);
    check(dozeEnNext === 1'b1, "R6", dozeEnNext, 1);
    waitStrobe();
    measureGap(g);
    check(g == 4, "R6", g, 4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule